// File: doc/BRIEF.md
# Serial Port with Independent Channel Enables

A memory-mapped serial port that moves bytes between a simple single-cycle register bus and a pair of serial lines. It uses one start bit, eight data bits sent least significant bit first, and one stop bit. Software queues bytes into an 8-entry transmit FIFO, and the transmitter drains that FIFO onto the serial output. The receiver samples the serial input at mid-bit and queues complete bytes into an 8-entry receive FIFO, which software reads back. A 16-bit divisor register sets how many clock cycles each bit lasts.

Each direction has its own enable bit. The enable gates FIFO traffic and does not reset the channel. With the transmit enable clear, queued bytes stay in the FIFO and the line rests high. Setting the enable again resumes draining where it stopped. With the receive enable clear, the input pin is ignored. Two level interrupt outputs compare each FIFO's occupancy against a 3-bit watermark held in that channel's control register.

Top module: `uart_chan_en`

## Requirements
- R1: While the transmit enable (bit 0 of the transmit control register) is 0, no frame starts, the transmit FIFO keeps its contents, and txd is held at 1 once any frame in progress has ended.
- R2: A frame already on the line when the transmit enable is cleared completes all ten bits. After it, txd stays high and the next queued byte is not started.
- R3: Setting the transmit enable while the transmit FIFO holds bytes resumes transmission of those bytes in the order they were written.
- R4: Reading the transmit data register returns 1 in bit 31 exactly when the transmit FIFO holds 8 bytes. A write to the transmit data register while the FIFO is full is dropped and leaves the queued bytes unchanged.
- R5: A frame is a 0 start bit, data bits 0 to 7, and a 1 stop bit, each lasting the divisor value in clock cycles. Divisor values 0 and 1 act as 2. One idle-high cycle separates back-to-back frames. A frame starts on the clock edge after the cycle in which the enable is set and a byte is queued.
- R6: While the receive enable (bit 0 of the receive control register) is 0, activity on rxd places no byte into the receive FIFO.
- R7: A byte that completes while the receive FIFO holds 8 bytes is dropped, and the 8 stored bytes are kept in order.
- R8: Reading the receive data register returns the oldest byte in bits 7:0 and an empty flag in bit 31. A read removes the byte only when the FIFO is not empty.
- R9: irq_tx is 1 exactly while the transmit FIFO occupancy is less than the transmit watermark in bits 18:16 of the transmit control register.
- R10: irq_rx is 1 exactly while the receive FIFO occupancy is greater than the receive watermark in bits 18:16 of the receive control register.
- R11: A low pulse on rxd that has ended by mid-bit is not taken as a start bit. A frame whose stop bit samples 0 is discarded.
- R12: Register byte offsets are 0x00 transmit data, 0x04 receive data, 0x08 transmit control, 0x0C receive control and 0x10 divisor. Control registers read back bit 0 and bits 18:16. After reset both enables and watermarks are 0, both FIFOs are empty, the divisor reads 16, txd is 1 and both interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, asynchronous |
| irq_tx | output | 1 | Transmit watermark interrupt |
| irq_rx | output | 1 | Receive watermark interrupt |

## Verification
The transmit path runs against a cycle-exact behavioural model under four patterns, and the model's line level and interrupt are compared on every clock:
- A queue loaded while the channel is disabled separates gated draining from draining that starts by itself.
- Disabling in the middle of the second frame separates finishing the current frame from aborting it or going on to the next.
- Overfilling the queue to nine writes separates a dropped write from an overwritten entry.
- A divisor of 1 exposes the minimum bit length.

The receive path is driven with clean frames while disabled and while enabled, a one-cycle glitch, a frame with a low stop bit, and ten back-to-back frames. Together these show the enable gating, the false-start and framing rejection, and overflow that keeps the oldest bytes.

// File: rtl/uart_pkg.sv
package uart_pkg;

  localparam int DIV_W      = 16;
  localparam int FIFO_DEPTH = 8;
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
  localparam int MARK_W     = 3;

  localparam int OFF_TXDATA = 'h00;
  localparam int OFF_RXDATA = 'h04;
  localparam int OFF_TXCTRL = 'h08;
  localparam int OFF_RXCTRL = 'h0C;
  localparam int OFF_DIV    = 'h10;

  localparam int MARK_LSB   = 16;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  // Bit period in cycles; anything below 2 is raised to 2.
  function automatic logic [DIV_W-1:0] bit_period(input logic [DIV_W-1:0] div);
    return (div < DIV_W'(2)) ? DIV_W'(2) : div;
  endfunction

  // Transmit watermark: occupancy strictly below the mark.
  function automatic logic below_mark(input logic [CNT_W-1:0] occ,
                                      input logic [MARK_W-1:0] mark);
    return occ < CNT_W'(mark);
  endfunction

  // Receive watermark: occupancy strictly above the mark.
  function automatic logic above_mark(input logic [CNT_W-1:0] occ,
                                      input logic [MARK_W-1:0] mark);
    return occ > CNT_W'(mark);
  endfunction

endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= next_ptr(wp);
      if (do_pop)  rp <= next_ptr(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] period,
  input  logic             start,
  input  logic [7:0]       data,
  output logic             busy,
  output logic             txd
);

  localparam int FRAME_BITS = 10;
  localparam int BIT_CNT_W  = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] shreg;
  logic [DIV_W-1:0]      cyc;
  logic [BIT_CNT_W-1:0]  bitn;
  logic                  bit_end;

  assign bit_end = (cyc == period - 1'b1);
  assign txd     = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      shreg <= '1;
      cyc   <= '0;
      bitn  <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      shreg <= {1'b1, data, 1'b0};
      cyc   <= '0;
      bitn  <= '0;
    end else if (busy) begin
      if (bit_end) begin
        cyc <= '0;
        if (bitn == BIT_CNT_W'(FRAME_BITS - 1)) begin
          busy <= 1'b0;
        end else begin
          shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
          bitn  <= bitn + 1'b1;
        end
      end else begin
        cyc <= cyc + 1'b1;
      end
    end
  end

endmodule

// File: rtl/uart_rx_shift.sv
module uart_rx_shift
  import uart_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] period,
  input  logic             enable,
  input  logic             rxd_async,
  output logic             valid,
  output logic [7:0]       data
);

  logic             sync1, sync2;
  rx_state_e        state;
  logic [DIV_W-1:0] cyc;
  logic [2:0]       bitn;
  logic [DIV_W-1:0] half;
  logic             bit_end, mid_start;

  assign half      = period >> 1;
  assign bit_end   = (cyc == period - 1'b1);
  assign mid_start = (cyc == half - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
    end else begin
      sync1 <= rxd_async;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      cyc   <= '0;
      bitn  <= '0;
      data  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (!enable) begin
        state <= RX_IDLE;
        cyc   <= '0;
      end else begin
        case (state)
          RX_IDLE: begin
            cyc <= '0;
            if (!sync2) state <= RX_START;
          end
          RX_START: begin
            if (mid_start) begin
              cyc   <= '0;
              bitn  <= '0;
              state <= sync2 ? RX_IDLE : RX_DATA;
            end else begin
              cyc <= cyc + 1'b1;
            end
          end
          RX_DATA: begin
            if (bit_end) begin
              cyc  <= '0;
              data <= {sync2, data[7:1]};
              if (bitn == 3'd7) state <= RX_STOP;
              else              bitn  <= bitn + 1'b1;
            end else begin
              cyc <= cyc + 1'b1;
            end
          end
          RX_STOP: begin
            if (bit_end) begin
              valid <= sync2;
              state <= RX_IDLE;
              cyc   <= '0;
            end else begin
              cyc <= cyc + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/uart_chan_en.sv
module uart_chan_en
  import uart_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DIV_RESET = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              txd,
  input  logic              rxd,
  output logic              irq_tx,
  output logic              irq_rx
);

  localparam logic [ADDR_W-1:0] A_TXDATA = ADDR_W'(OFF_TXDATA);
  localparam logic [ADDR_W-1:0] A_RXDATA = ADDR_W'(OFF_RXDATA);
  localparam logic [ADDR_W-1:0] A_TXCTRL = ADDR_W'(OFF_TXCTRL);
  localparam logic [ADDR_W-1:0] A_RXCTRL = ADDR_W'(OFF_RXCTRL);
  localparam logic [ADDR_W-1:0] A_DIV    = ADDR_W'(OFF_DIV);
  localparam int               MARK_MSB = MARK_LSB + MARK_W - 1;

  logic              tx_en, rx_en;
  logic [MARK_W-1:0] tx_mark, rx_mark;
  logic [DIV_W-1:0]  div_reg, period;

  logic              wr_any, rd_any;
  logic              tx_push, tx_start, tx_busy, tx_full, tx_empty;
  logic [7:0]        tx_head;
  logic [CNT_W-1:0]  tx_count;
  logic              rx_valid, rx_push, rx_pop, rx_full, rx_empty;
  logic [7:0]        rx_byte, rx_head;
  logic [CNT_W-1:0]  rx_count;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata[31:MARK_MSB+1];

  assign wr_any   = bus_sel && bus_wr;
  assign rd_any   = bus_sel && !bus_wr;
  assign period   = bit_period(div_reg);

  assign tx_push  = wr_any && (bus_addr == A_TXDATA);
  assign tx_start = tx_en && !tx_busy && !tx_empty;
  assign rx_pop   = rd_any && (bus_addr == A_RXDATA) && !rx_empty;
  assign rx_push  = rx_valid && !rx_full;

  assign irq_tx   = below_mark(tx_count, tx_mark);
  assign irq_rx   = above_mark(rx_count, rx_mark);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en   <= 1'b0;
      rx_en   <= 1'b0;
      tx_mark <= '0;
      rx_mark <= '0;
      div_reg <= DIV_W'(DIV_RESET);
    end else if (wr_any) begin
      case (bus_addr)
        A_TXCTRL: begin
          tx_en   <= bus_wdata[0];
          tx_mark <= bus_wdata[MARK_MSB:MARK_LSB];
        end
        A_RXCTRL: begin
          rx_en   <= bus_wdata[0];
          rx_mark <= bus_wdata[MARK_MSB:MARK_LSB];
        end
        A_DIV:   div_reg <= bus_wdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_any) begin
      case (bus_addr)
        A_TXDATA: bus_rdata[31] = tx_full;
        A_RXDATA: begin
          bus_rdata[31]  = rx_empty;
          bus_rdata[7:0] = rx_empty ? 8'h00 : rx_head;
        end
        A_TXCTRL: begin
          bus_rdata[0]                 = tx_en;
          bus_rdata[MARK_MSB:MARK_LSB] = tx_mark;
        end
        A_RXCTRL: begin
          bus_rdata[0]                 = rx_en;
          bus_rdata[MARK_MSB:MARK_LSB] = rx_mark;
        end
        A_DIV:   bus_rdata[DIV_W-1:0] = div_reg;
        default: bus_rdata = '0;
      endcase
    end
  end

  uart_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (tx_push),
    .wdata (bus_wdata[7:0]),
    .pop   (tx_start),
    .rdata (tx_head),
    .count (tx_count),
    .full  (tx_full),
    .empty (tx_empty)
  );

  uart_tx_shift u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .period (period),
    .start  (tx_start),
    .data   (tx_head),
    .busy   (tx_busy),
    .txd    (txd)
  );

  uart_rx_shift u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .period    (period),
    .enable    (rx_en),
    .rxd_async (rxd),
    .valid     (rx_valid),
    .data      (rx_byte)
  );

  uart_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rx_push),
    .wdata (rx_byte),
    .pop   (rx_pop),
    .rdata (rx_head),
    .count (rx_count),
    .full  (rx_full),
    .empty (rx_empty)
  );

endmodule

// File: rtl/uart_chan_en_chk.sv
module uart_chan_en_chk
  import uart_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             txd,
  input logic             tx_en,
  input logic             tx_busy,
  input logic             tx_start,
  input logic             tx_full,
  input logic [CNT_W-1:0] tx_count,
  input logic             rx_en,
  input logic             rx_push,
  input logic             rx_pop,
  input logic             rx_full,
  input logic [CNT_W-1:0] rx_count
);

  // R1: idle line is high
  assert_txd_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  // R1: a frame only begins after a cycle with the enable set
  assert_start_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(tx_en));

  // R5: a start leads to a low start bit
  assert_start_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> (tx_busy && !txd));

  // R4: a full transmit queue does not grow
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && !tx_start) |=> (tx_count == $past(tx_count)));

  // R6: disabled receiver queues nothing
  assert_rx_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_push);

  // R7: a full receive queue stays full until read
  assert_rx_full_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rx_pop) |=> rx_full);

  // R8: a read pop removes exactly one entry
  assert_rx_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && !rx_push) |=> ((rx_count + 1'b1) == $past(rx_count)));

endmodule

bind uart_chan_en uart_chan_en_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .txd      (txd),
  .tx_en    (tx_en),
  .tx_busy  (tx_busy),
  .tx_start (tx_start),
  .tx_full  (tx_full),
  .tx_count (tx_count),
  .rx_en    (rx_en),
  .rx_push  (rx_push),
  .rx_pop   (rx_pop),
  .rx_full  (rx_full),
  .rx_count (rx_count)
);

// File: tb/sim_uart_chan_en.sv
`timescale 1ns/1ps
module sim_uart_chan_en;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        txd;
  logic        rxd = 1'b1;
  logic        irq_tx, irq_rx;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit live = 1'b0;
  string phase = "R5";

  always #4 clk = ~clk;

  uart_chan_en u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .txd(txd), .rxd(rxd), .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // ---------------- transmit reference model ----------------
  logic [7:0] q[$];
  bit         m_en, m_busy;
  int         m_wm, m_div, m_fc;
  logic [7:0] m_byte;

  function automatic int eff_of(input int d);
    return (d < 2) ? 2 : d;
  endfunction

  function automatic logic model_txd();
    logic [9:0] frame;
    if (!m_busy) return 1'b1;
    frame = {1'b1, m_byte, 1'b0};
    return frame[m_fc / eff_of(m_div)];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_en = 0; m_busy = 0; m_wm = 0; m_div = 16; m_fc = 0; m_byte = 0;
    end else begin
      bit go, full_pre;
      go = m_en && !m_busy && (q.size() > 0);
      full_pre = (q.size() == 8);
      if (m_busy) begin
        if (m_fc == 10 * eff_of(m_div) - 1) m_busy = 0;
        else m_fc++;
      end
      if (go) begin
        m_byte = q.pop_front();
        m_busy = 1; m_fc = 0;
      end
      if (bus_sel && bus_wr) begin
        case (bus_addr)
          5'h00: if (!full_pre) q.push_back(bus_wdata[7:0]);
          5'h08: begin m_en = bus_wdata[0]; m_wm = int'(bus_wdata[18:16]); end
          5'h10: m_div = int'(bus_wdata[15:0]);
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (live && rst_n) begin
      chk(phase, "txd vs model", {31'b0, txd}, {31'b0, model_txd()});
      chk("R9", "irq_tx vs model", {31'b0, irq_tx},
          {31'b0, (q.size() < m_wm)});
    end
  end

  // ---------------- bus and line tasks ----------------
  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic line_bit(input logic v, input int p);
    rxd = v;
    repeat (p) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stopv);
    @(negedge clk);
    line_bit(1'b0, 4);
    for (int i = 0; i < 8; i++) line_bit(b[i], 4);
    line_bit(stopv, 4);
    rxd = 1'b1;
    idle(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    live = 1'b1;

    // R12 reset state and register map
    chk("R12", "txd at reset", {31'b0, txd}, 32'h1);
    chk("R12", "irq_tx at reset", {31'b0, irq_tx}, 32'h0);
    chk("R12", "irq_rx at reset", {31'b0, irq_rx}, 32'h0);
    bus_read(5'h08, d); chk("R12", "txctrl reset", d, 32'h0);
    bus_read(5'h0C, d); chk("R12", "rxctrl reset", d, 32'h0);
    bus_read(5'h10, d); chk("R12", "divisor reset", d, 32'd16);
    bus_read(5'h04, d); chk("R8",  "rx empty at reset", d, 32'h8000_0000);
    bus_read(5'h00, d); chk("R4",  "tx not full at reset", d, 32'h0);

    // R1: queue while disabled
    bus_write(5'h10, 32'd4);
    phase = "R1";
    bus_write(5'h08, 32'h0004_0000);
    bus_read(5'h08, d); chk("R12", "txctrl readback", d, 32'h0004_0000);
    bus_write(5'h00, 32'hA5);
    bus_write(5'h00, 32'h3C);
    bus_write(5'h00, 32'h81);
    idle(100);
    chk("R1", "queue kept while disabled", q.size(), 3);

    // R3 enable drains, then R2 disable mid second frame
    phase = "R3";
    bus_write(5'h08, 32'h0004_0001);
    idle(55);
    phase = "R2";
    bus_write(5'h08, 32'h0004_0000);
    idle(150);
    chk("R2", "one byte left after mid-frame disable", q.size(), 1);
    chk("R2", "line idle after frame", {31'b0, txd}, 32'h1);
    phase = "R3";
    bus_write(5'h08, 32'h0004_0001);
    idle(60);
    chk("R3", "queue drained after re-enable", q.size(), 0);

    // R4 overfill while disabled
    phase = "R4";
    bus_write(5'h08, 32'h0004_0000);
    for (int i = 0; i < 9; i++) bus_write(5'h00, 32'h10 + i);
    bus_read(5'h00, d); chk("R4", "full flag", d, 32'h8000_0000);
    chk("R4", "ninth write dropped", q.size(), 8);
    bus_write(5'h08, 32'h0004_0001);
    idle(8 * 41 + 20);
    bus_read(5'h00, d); chk("R4", "full flag clear after drain", d, 32'h0);

    // R5 minimum divisor
    phase = "R5";
    bus_write(5'h10, 32'd1);
    bus_read(5'h10, d); chk("R5", "divisor readback", d, 32'd1);
    bus_write(5'h00, 32'h96);
    idle(30);
    bus_write(5'h10, 32'd4);
    idle(5);

    // R6 receiver disabled
    bus_write(5'h0C, 32'h0001_0000);
    send_rx(8'h5A, 1'b1);
    bus_read(5'h04, d); chk("R6", "disabled rx stays empty", d, 32'h8000_0000);

    // R8/R10 enabled receive
    bus_write(5'h0C, 32'h0001_0001);
    bus_read(5'h0C, d); chk("R12", "rxctrl readback", d, 32'h0001_0001);
    send_rx(8'h5A, 1'b1);
    chk("R10", "irq_rx with one byte, mark 1", {31'b0, irq_rx}, 32'h0);
    send_rx(8'hC3, 1'b1);
    chk("R10", "irq_rx with two bytes, mark 1", {31'b0, irq_rx}, 32'h1);
    bus_read(5'h04, d); chk("R8", "first byte", d, 32'h5A);
    chk("R10", "irq_rx after one read", {31'b0, irq_rx}, 32'h0);
    bus_read(5'h04, d); chk("R8", "second byte", d, 32'hC3);
    bus_read(5'h04, d); chk("R8", "empty read", d, 32'h8000_0000);
    send_rx(8'h7E, 1'b1);
    bus_read(5'h04, d); chk("R8", "empty read did not pop later byte", d, 32'h7E);

    // R11 false start and bad stop
    @(negedge clk); rxd = 1'b0; @(negedge clk); rxd = 1'b1;
    idle(60);
    bus_read(5'h04, d); chk("R11", "glitch rejected", d, 32'h8000_0000);
    send_rx(8'h33, 1'b0);
    idle(10);
    bus_read(5'h04, d); chk("R11", "bad stop discarded", d, 32'h8000_0000);

    // R7 overflow
    bus_write(5'h0C, 32'h0007_0001);
    for (int i = 0; i < 10; i++) send_rx(8'h40 + 8'(i), 1'b1);
    chk("R10", "irq_rx full above mark 7", {31'b0, irq_rx}, 32'h1);
    for (int i = 0; i < 8; i++) begin
      bus_read(5'h04, d); chk("R7", "kept byte order", d, 32'h40 + i);
    end
    bus_read(5'h04, d); chk("R7", "extra bytes dropped", d, 32'h8000_0000);

    live = 1'b0;
    idle(2);
    finish_run();
  end

endmodule